// File: doc/BRIEF.md
# Chip-Select Bank Match Unit

This block sits between an internal bus and the external memory sequencer. It decides which of four programmable memory banks an access falls into. Software sets each bank up through a small register port. Each bank has a base word holding a 17-bit base address and a valid flag. Each bank also has an option word holding a 17-bit compare mask and the bank's access attributes. The attributes are a read-only flag, a wait-state count for single accesses, a wait-state count for each burst beat, a burst-inhibit flag and a port width code.

The requester presents the upper 17 bits of its address, a write flag and a request strobe. The block compares those bits against every valid bank. Only the positions enabled in each bank's mask take part in the compare. When several banks hit, the lowest-numbered one wins. In the following cycle the block drives a one-hot chip select and the winner's attributes. If no bank hits, it drives a no-match flag instead. A write that lands in a read-only bank is blocked and raises a violation pulse. It also sets a sticky per-bank bit in a status word, which software clears by writing ones to it.

Top module: `cs_bank_match`

## Requirements
- R1: After reset, csOut is 0, noMatch and wpViol are 0, every valid flag reads back 0 and the status word reads 0.
- R2: Register map on regAddr: 0..3 are the base words of banks 0..3, laid out as base in bits [31:15] and valid in bit 0. 4..7 are the option words of banks 0..3, laid out as mask [31:15], readOnly [14], singleWait [13:10], burstWait [9:6], burstInhibit [5] and portSize [4:3]. portSize uses 0=8-bit, 1=16-bit and 2=32-bit. Address 8 is the status word, with bit i for bank i. Written fields read back unchanged on regRdData in the same cycle, and unused bits read 0.
- R3: A bank whose valid flag is 0 never matches, whatever its base and mask.
- R4: reqAddr bit j is compared with base bit j only where mask bit j is 1. Positions with mask bit 0 are ignored.
- R5: When several banks match, csOut selects the lowest-numbered one and the attributes come from that bank.
- R6: One cycle after a cycle with reqValid high that matches and is not blocked, csOut is the one-hot winner and the attribute outputs show the winner's fields.
- R7: One cycle after a cycle with reqValid high that matches no bank, noMatch is 1 and csOut is 0.
- R8: A write request whose winning bank is read-only gives, one cycle later, csOut 0 and wpViol 1, with attrReadOnly 1. In the same cycle the winner's status bit becomes 1.
- R9: A status bit stays 1 until a status write with a 1 in that position. Writing 0 there leaves it set, and a new violation in the same cycle as a clear keeps it set.
- R10: A read request to a read-only bank is not blocked. It asserts that bank's chip select.
- R11: One cycle after a cycle with reqValid low, csOut is 0 and noMatch and wpViol are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | 17 | Upper 17 bus address bits of the request |
| csOut | output | 4 | Registered one-hot chip select |
| noMatch | output | 1 | Registered: last request hit no bank |
| wpViol | output | 1 | Registered: last request was a blocked write |
| attrReadOnly | output | 1 | Winner read-only flag |
| attrSingleWait | output | 4 | Winner single-access wait states |
| attrBurstWait | output | 4 | Winner per-beat wait states |
| attrBurstInhibit | output | 1 | Winner burst-inhibit flag |
| attrPortSize | output | 2 | Winner port width code |

## Verification
Register readback is combinational, so the bench checks it a moment after setting regAddr, with no clock edge in between. Request results (chip select, no-match, violation, attributes) come out one register stage behind the request. The bench therefore drives a request on a falling edge and samples just after the next rising edge. The status bit is set on that same edge, and its clear takes effect on the edge that captures the status write. The bench reads it back only after that edge.

// File: rtl/csbm_pkg.sv
package csbm_pkg;
  localparam int NUM_BANKS = 4;
  localparam int CMP_W     = 17;
  localparam int WS_W      = 4;
  localparam int PS_W      = 2;
  localparam int DATA_W    = 32;
  localparam int RADDR_W   = 4;
  localparam int BIDX_W    = $clog2(NUM_BANKS);
  localparam int STAT_ADDR = 2 * NUM_BANKS;

  typedef struct packed {
    logic            readOnly;
    logic [WS_W-1:0] singleWait;
    logic [WS_W-1:0] burstWait;
    logic            burstInhibit;
    logic [PS_W-1:0] portSize;
  } bank_attr_t;

  localparam int ATTR_W   = $bits(bank_attr_t);
  localparam int ATTR_LSB = 3;
  localparam int FLD_LSB  = DATA_W - CMP_W;

  typedef struct packed {
    logic [NUM_BANKS-1:0] baseWe;
    logic [NUM_BANKS-1:0] optWe;
    logic                 statClr;
    logic                 accept;
    logic                 accWrite;
  } csbm_strobe_t;
endpackage

// File: rtl/csbm_ctrl.sv
module csbm_ctrl
  import csbm_pkg::*;
(
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic               reqValid,
  input  logic               reqWrite,
  output csbm_strobe_t       stb
);
  logic isOpt;
  logic inBankRange;
  logic [BIDX_W-1:0] bankIdx;

  assign isOpt       = regAddr[BIDX_W];
  assign bankIdx     = regAddr[BIDX_W-1:0];
  assign inBankRange = (regAddr < RADDR_W'(STAT_ADDR));

  always_comb begin
    stb = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      stb.baseWe[i] = regWrEn && inBankRange && !isOpt && (bankIdx == BIDX_W'(i));
      stb.optWe[i]  = regWrEn && inBankRange &&  isOpt && (bankIdx == BIDX_W'(i));
    end
    stb.statClr  = regWrEn && (regAddr == RADDR_W'(STAT_ADDR));
    stb.accept   = reqValid;
    stb.accWrite = reqValid && reqWrite;
  end
endmodule

// File: rtl/csbm_dpath.sv
module csbm_dpath
  import csbm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  csbm_strobe_t       stb,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [CMP_W-1:0]   reqAddr,
  output logic [NUM_BANKS-1:0] csOut,
  output logic               noMatch,
  output logic               wpViol,
  output bank_attr_t         attrOut,
  output logic [NUM_BANKS-1:0] statVec
);
  logic [NUM_BANKS-1:0] validQ;
  logic [CMP_W-1:0]     baseQ [NUM_BANKS];
  logic [CMP_W-1:0]     maskQ [NUM_BANKS];
  bank_attr_t           attrQ [NUM_BANKS];
  logic [NUM_BANKS-1:0] hitVec;

  logic [NUM_BANKS-1:0] selOh;
  bank_attr_t           selAttr;
  logic                 anyHit;
  logic                 blockWr;
  logic [NUM_BANKS-1:0] statQ;

  // Per-bank register storage and masked compare
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        validQ[g] <= 1'b0;
        baseQ[g]  <= '0;
      end else if (stb.baseWe[g]) begin
        validQ[g] <= regWrData[0];
        baseQ[g]  <= regWrData[DATA_W-1:FLD_LSB];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maskQ[g] <= '0;
        attrQ[g] <= '0;
      end else if (stb.optWe[g]) begin
        maskQ[g] <= regWrData[DATA_W-1:FLD_LSB];
        attrQ[g] <= regWrData[ATTR_LSB+ATTR_W-1:ATTR_LSB];
      end
    end

    assign hitVec[g] = validQ[g] && (((reqAddr ^ baseQ[g]) & maskQ[g]) == '0);
  end

  // Fixed priority: lowest index wins (loop runs downward, last write wins)
  always_comb begin
    selOh   = '0;
    selAttr = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selOh    = '0;
        selOh[i] = 1'b1;
        selAttr  = attrQ[i];
      end
    end
    anyHit  = |hitVec;
    blockWr = stb.accWrite && anyHit && selAttr.readOnly;
  end

  // Registered access results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csOut   <= '0;
      noMatch <= 1'b0;
      wpViol  <= 1'b0;
      attrOut <= '0;
    end else begin
      csOut   <= (stb.accept && anyHit && !blockWr) ? selOh : '0;
      noMatch <= stb.accept && !anyHit;
      wpViol  <= blockWr;
      if (stb.accept && anyHit) attrOut <= selAttr;
    end
  end

  // Sticky violation status, write-one-to-clear, set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statQ <= '0;
    end else begin
      statQ <= (statQ & ~(stb.statClr ? regWrData[NUM_BANKS-1:0] : '0))
             | (blockWr ? selOh : '0);
    end
  end
  assign statVec = statQ;

  // Combinational register readback
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (regAddr == RADDR_W'(i)) begin
        regRdData[DATA_W-1:FLD_LSB] = baseQ[i];
        regRdData[0]                = validQ[i];
      end
      if (regAddr == RADDR_W'(NUM_BANKS + i)) begin
        regRdData[DATA_W-1:FLD_LSB]             = maskQ[i];
        regRdData[ATTR_LSB+ATTR_W-1:ATTR_LSB]   = attrQ[i];
      end
    end
    if (regAddr == RADDR_W'(STAT_ADDR)) regRdData[NUM_BANKS-1:0] = statQ;
  end
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import csbm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [RADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [CMP_W-1:0]     reqAddr,
  output logic [NUM_BANKS-1:0] csOut,
  output logic                 noMatch,
  output logic                 wpViol,
  output logic                 attrReadOnly,
  output logic [WS_W-1:0]      attrSingleWait,
  output logic [WS_W-1:0]      attrBurstWait,
  output logic                 attrBurstInhibit,
  output logic [PS_W-1:0]      attrPortSize
);
  csbm_strobe_t         stb;
  bank_attr_t           attrOut;
  logic [NUM_BANKS-1:0] statVec;

  csbm_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .stb     (stb)
  );

  csbm_dpath dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .reqAddr  (reqAddr),
    .csOut    (csOut),
    .noMatch  (noMatch),
    .wpViol   (wpViol),
    .attrOut  (attrOut),
    .statVec  (statVec)
  );

  assign attrReadOnly     = attrOut.readOnly;
  assign attrSingleWait   = attrOut.singleWait;
  assign attrBurstWait    = attrOut.burstWait;
  assign attrBurstInhibit = attrOut.burstInhibit;
  assign attrPortSize     = attrOut.portSize;
endmodule

// File: rtl/csbm_checker.sv
module csbm_checker
  import csbm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reqValid,
  input logic [NUM_BANKS-1:0] csOut,
  input logic                 noMatch,
  input logic                 wpViol,
  input logic                 attrReadOnly,
  input logic [NUM_BANKS-1:0] statVec
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csOut)); // R5

  AST_NOMATCH_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    noMatch |-> (csOut == '0)); // R7

  AST_WP_BLOCKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wpViol |-> (csOut == '0 && attrReadOnly && !noMatch)); // R8

  AST_WP_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    wpViol |-> (statVec != '0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (csOut == '0 && !noMatch && !wpViol)); // R11
endmodule

bind cs_bank_match csbm_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .csOut       (csOut),
  .noMatch     (noMatch),
  .wpViol      (wpViol),
  .attrReadOnly(attrReadOnly),
  .statVec     (statVec)
);

// File: tb/cs_bank_match_tb_top.sv
module cs_bank_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [3:0]  csOut;
  logic        noMatch, wpViol, attrReadOnly, attrBurstInhibit;
  logic [3:0]  attrSingleWait, attrBurstWait;
  logic [1:0]  attrPortSize;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_bank_match dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .csOut(csOut), .noMatch(noMatch),
    .wpViol(wpViol), .attrReadOnly(attrReadOnly), .attrSingleWait(attrSingleWait),
    .attrBurstWait(attrBurstWait), .attrBurstInhibit(attrBurstInhibit),
    .attrPortSize(attrPortSize)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] baseWord(logic [16:0] b, logic v);
    return {b, 14'b0, v};
  endfunction

  function automatic logic [31:0] optWord(logic [16:0] m, logic ro, logic [3:0] sw,
                                          logic [3:0] bw, logic bi, logic [1:0] ps);
    return {m, ro, sw, bw, bi, ps, 3'b0};
  endfunction

  // Request on a falling edge, results sampled just after the next rising edge
  task automatic access(logic [16:0] a, logic wr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 csOut", 32'(csOut), 0);
    chk("R1 noMatch", 32'(noMatch), 0);
    chk("R1 wpViol", 32'(wpViol), 0);
    for (int i = 0; i < 4; i++) begin
      regRead(4'(i), d);
      chk("R1 valid", 32'(d[0]), 0);
    end
    regRead(4'd8, d);
    chk("R1 status", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    regWrite(4'd1, baseWord(17'h0ABCD, 1'b1));
    regWrite(4'd5, optWord(17'h1F0F0, 1'b1, 4'd9, 4'd3, 1'b1, 2'd1));
    regRead(4'd1, d);
    chk("R2 base readback", d, baseWord(17'h0ABCD, 1'b1));
    regRead(4'd5, d);
    chk("R2 option readback", d, optWord(17'h1F0F0, 1'b1, 4'd9, 4'd3, 1'b1, 2'd1));
    regWrite(4'd1, 32'hFFFF_FFFF);
    regRead(4'd1, d);
    chk("R2 reserved bits read 0", d, baseWord(17'h1FFFF, 1'b1));
    regWrite(4'd1, 0);
    regWrite(4'd5, 0);
  endtask

  task automatic t_invalid();
    regWrite(4'd0, baseWord(17'h00100, 1'b0));
    regWrite(4'd4, optWord(17'h1FFFF, 1'b0, 4'd1, 4'd1, 1'b0, 2'd2));
    access(17'h00100, 1'b0);
    chk("R3 invalid bank no cs", 32'(csOut), 0);
    chk("R3 invalid bank noMatch", 32'(noMatch), 1);
  endtask

  task automatic t_mask();
    regWrite(4'd0, baseWord(17'h10000, 1'b1));
    regWrite(4'd4, optWord(17'h1FF00, 1'b0, 4'd5, 4'd2, 1'b0, 2'd2));
    access(17'h100A5, 1'b0);
    chk("R4 unmasked bits ignored", 32'(csOut), 32'h1);
    chk("R6 single wait", 32'(attrSingleWait), 5);
    chk("R6 port size", 32'(attrPortSize), 2);
    access(17'h10100, 1'b0);
    chk("R4 masked bit differs", 32'(csOut), 0);
    chk("R7 noMatch", 32'(noMatch), 1);
    regWrite(4'd0, 0);
  endtask

  task automatic t_priority();
    regWrite(4'd1, baseWord(17'h04000, 1'b1));
    regWrite(4'd5, optWord(17'h1C000, 1'b0, 4'd7, 4'd4, 1'b1, 2'd0));
    regWrite(4'd2, baseWord(17'h04400, 1'b1));
    regWrite(4'd6, optWord(17'h1FF00, 1'b0, 4'd2, 4'd1, 1'b0, 2'd1));
    access(17'h04412, 1'b0);
    chk("R5 lowest wins", 32'(csOut), 32'h2);
    chk("R5 attrs from winner", {attrSingleWait, attrBurstWait, 2'(attrPortSize), 1'(attrBurstInhibit)},
        {4'd7, 4'd4, 2'd0, 1'b1});
    regWrite(4'd1, baseWord(17'h04000, 1'b0));
    access(17'h04412, 1'b0);
    chk("R5 next bank when lower invalid", 32'(csOut), 32'h4);
    chk("R6 burst wait", 32'(attrBurstWait), 1);
    regWrite(4'd2, 0);
  endtask

  task automatic t_wp();
    logic [31:0] d;
    regWrite(4'd3, baseWord(17'h1E000, 1'b1));
    regWrite(4'd7, optWord(17'h1F000, 1'b1, 4'd3, 4'd3, 1'b0, 2'd2));
    access(17'h1E123, 1'b1);
    chk("R8 write blocked", 32'(csOut), 0);
    chk("R8 wpViol", 32'(wpViol), 1);
    chk("R8 attrReadOnly", 32'(attrReadOnly), 1);
    regRead(4'd8, d);
    chk("R8 status bit", d, 32'h8);
    access(17'h1E123, 1'b0);
    chk("R10 read allowed", 32'(csOut), 32'h8);
    chk("R10 no violation", 32'(wpViol), 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    regRead(4'd8, d);
    chk("R9 sticky after read", d, 32'h8);
    regWrite(4'd8, 32'h7);
    regRead(4'd8, d);
    chk("R9 write 0 keeps", d, 32'h8);
    regWrite(4'd8, 32'h8);
    regRead(4'd8, d);
    chk("R9 write 1 clears", d, 0);
    // violation and clear in the same cycle: set wins
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd8; regWrData = 32'h8;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h1E000;
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    regRead(4'd8, d);
    chk("R9 set beats clear", d, 32'h8);
  endtask

  task automatic t_idle();
    access(17'h00000, 1'b0);
    @(negedge clk);
    @(posedge clk);
    #1;
    chk("R11 idle csOut", 32'(csOut), 0);
    chk("R11 idle noMatch", 32'(noMatch), 0);
    chk("R11 idle wpViol", 32'(wpViol), 0);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_invalid();
    t_mask();
    t_priority();
    t_wp();
    t_sticky();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule